// File: doc/BRIEF.md
# Multi-mode shift and rotate unit

This block moves the bits of a W-bit word by a run-time amount, in one of six ways. It can shift logically or arithmetically in either direction, or it can rotate in either direction. The amount is a two's-complement number. A negative amount keeps the kind of operation and turns its direction around. Two flags report that a non-rotating shift discarded a 1. The upper flag means a multiply by 2^k gave the wrong product. The lower flag means a divide by 2^k lost a remainder.

The datapath is pure combinational logic. A parameter selects whether result, flags and a valid bit pass straight through to the outputs or are captured in a register on the rising clock edge. The register has a synchronous reset.

Top module: `shift_rotate_unit`

## Requirements
- R1: Op code 000 shifts toward the MSB and op code 001 shifts toward the LSB. Both fill the vacated positions with 0, and an amount of magnitude W or more gives all zeros.
- R2: Op code 010 shifts toward the MSB and fills the k vacated low bits with the input's bit 0. Op code 011 shifts toward the LSB and fills the k vacated high bits with the input's bit W-1. A magnitude of W or more gives every bit equal to that fill bit.
- R3: Op code 100 rotates toward the MSB and op code 101 rotates toward the LSB, both by the magnitude modulo W. With W=5, 10011 rotated toward the MSB by 2 is 01110.
- R4: A negative amount performs the opposite direction of the selected operation with the same magnitude. Code 000 with -2 equals code 001 with 2, and the flags follow the effective direction.
- R5: left_lost is 1 exactly when a non-rotating shift whose effective direction is toward the MSB drops at least one 1 bit out of the top.
- R6: right_lost is 1 exactly when a non-rotating shift whose effective direction is toward the LSB drops at least one 1 bit out of the bottom.
- R7: Op codes 110 and 111 output data_in unchanged, with both flags 0.
- R8: Rotations never raise a flag. An amount of 0 returns data_in unchanged, with both flags 0, for every op code.
- R9: With REGISTERED=1, result, flags and out_valid (a copy of in_valid) update on the rising edge after the inputs, and rst held at a rising edge clears all of them to 0. With REGISTERED=0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a meaningful input word |
| data_in | input | W | Word to shift or rotate |
| amount | input | AMT_W | Signed shift amount |
| op | input | 3 | Operation select |
| data_out | output | W | Shifted or rotated word |
| left_lost | output | 1 | A 1 bit left through the top |
| right_lost | output | 1 | A 1 bit left through the bottom |
| out_valid | output | 1 | Copy of in_valid, aligned with data_out |

## Verification
The assertions assume that data_in, amount and op carry known 0/1 values whenever rst is low. They assume nothing about the range of amount, and the most negative value is legal, with magnitude 2^(AMT_W-1). The stimulus drives only defined values, from negedge tasks. It covers every op code, amounts across the full signed range including that most negative value, and magnitudes at and beyond W. Directed vectors are placed at the fill and flag edges, and random words make up the rest.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int W = 8,
  parameter int AMT_W = 5,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [W-1:0]            data_in,
  input  logic signed [AMT_W-1:0] amount,
  input  logic [2:0]              op,
  output logic [W-1:0]            data_out,
  output logic                    left_lost,
  output logic                    right_lost,
  output logic                    out_valid
);

  localparam logic [W-1:0] ONES = '1;

  logic [AMT_W-1:0] mag;
  logic             neg, go_left, is_rot, is_pass, is_arith;
  int unsigned      k, rk;
  logic [W-1:0]     low_mask, high_mask, rot_l, rot_r, res;
  logic             lost_top, lost_bot, fl_left, fl_right;

  assign neg      = amount[AMT_W-1];
  assign mag      = neg ? (~amount + 1'b1) : amount;
  assign go_left  = ~(op[0] ^ neg);
  assign is_rot   = op[2] & ~op[1];
  assign is_pass  = op[2] & op[1];
  assign is_arith = ~op[2] & op[1];
  assign k        = 32'(mag);
  assign rk       = k % W;

  assign low_mask  = ~(ONES << k);
  assign high_mask = ~(ONES >> k);
  assign lost_top  = |(data_in & high_mask);
  assign lost_bot  = |(data_in & low_mask);

  assign rot_l = (rk == 0) ? data_in : ((data_in << rk) | (data_in >> (W - rk)));
  assign rot_r = (rk == 0) ? data_in : ((data_in >> rk) | (data_in << (W - rk)));

  always_comb begin
    res = data_in;
    if (is_pass)
      res = data_in;
    else if (is_rot)
      res = go_left ? rot_l : rot_r;
    else if (go_left)
      res = (data_in << k) | ((is_arith & data_in[0]) ? low_mask : '0);
    else
      res = (data_in >> k) | ((is_arith & data_in[W-1]) ? high_mask : '0);
  end

  assign fl_left  = ~is_pass & ~is_rot & go_left & lost_top;
  assign fl_right = ~is_pass & ~is_rot & ~go_left & lost_bot;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          data_out   <= '0;
          left_lost  <= 1'b0;
          right_lost <= 1'b0;
          out_valid  <= 1'b0;
        end else begin
          data_out   <= res;
          left_lost  <= fl_left;
          right_lost <= fl_right;
          out_valid  <= in_valid;
        end
      end

      a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !left_lost && !right_lost && data_out == '0));
      a_r7_pass_registered: assert property (@(posedge clk) disable iff (rst)
        (op[2] && op[1]) |=> (data_out == $past(data_in) && !left_lost && !right_lost));
    end else begin : g_comb
      assign data_out   = res;
      assign left_lost  = fl_left;
      assign right_lost = fl_right;
      assign out_valid  = in_valid;
    end
  endgenerate

  a_r8_rotate_no_flags: assert property (@(posedge clk) disable iff (rst)
    (op[2] && !op[1]) |-> (!fl_left && !fl_right));
  a_r8_zero_identity: assert property (@(posedge clk) disable iff (rst)
    (amount == '0) |-> (res == data_in && !fl_left && !fl_right));
  a_r5_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
    !(fl_left && fl_right));
  a_r7_pass_through: assert property (@(posedge clk) disable iff (rst)
    (op[2] && op[1]) |-> (res == data_in));

endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
  localparam int W = 8;
  localparam int AMT_W = 5;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [W-1:0] data_in = '0;
  logic signed [AMT_W-1:0] amount = '0;
  logic [2:0] op = '0;
  logic [W-1:0] data_out;
  logic left_lost, right_lost, out_valid;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit #(.W(W), .AMT_W(AMT_W), .REGISTERED(1'b1)) u_shift_rotate_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in), .amount(amount),
    .op(op), .data_out(data_out), .left_lost(left_lost), .right_lost(right_lost),
    .out_valid(out_valid));

  function automatic void model(input logic [W-1:0] d, input int amt, input int code,
                                output logic [W-1:0] r, output bit ll, output bit rl);
    bit left, rot, arith;
    int kk;
    r = d; ll = 0; rl = 0;
    if (code >= 6) return;
    left = ((code % 2) == 0);
    if (amt < 0) left = !left;
    kk = (amt < 0) ? -amt : amt;
    rot = (code >= 4);
    arith = (code == 2 || code == 3);
    for (int i = 0; i < W; i++) begin
      if (rot) begin
        if (left) r[i] = d[(i - (kk % W) + W) % W];
        else      r[i] = d[(i + kk) % W];
      end else if (left) begin
        r[i] = (i - kk >= 0) ? d[i - kk] : (arith ? d[0] : 1'b0);
        if (d[i] && i + kk >= W) ll = 1;
      end else begin
        r[i] = (i + kk < W) ? d[i + kk] : (arith ? d[W-1] : 1'b0);
        if (d[i] && i < kk) rl = 1;
      end
    end
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] d, input int amt, input int code, input string tag);
    logic [W-1:0] er;
    bit el, erl;
    model(d, amt, code, er, el, erl);
    @(negedge clk);
    data_in = d; amount = AMT_W'(amt); op = 3'(code); in_valid = 1'b1;
    @(negedge clk);
    check(tag, "data_out", int'(data_out), int'(er));
    check((el != left_lost) ? "R5" : tag, "left_lost", int'(left_lost), int'(el));
    check((erl != right_lost) ? "R6" : tag, "right_lost", int'(right_lost), int'(erl));
    check("R9", "out_valid", int'(out_valid), 1);
  endtask

  function automatic string tag_of(input int code);
    if (code < 2) return "R1";
    if (code < 4) return "R2";
    if (code < 6) return "R3";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9", "reset data_out", int'(data_out), 0);
    check("R9", "reset out_valid", int'(out_valid), 0);
    check("R9", "reset flags", int'({left_lost, right_lost}), 0);
    rst = 1'b0;

    step(8'b0110_0000, 1, 0, "R1");
    step(8'b1111_0000, 8, 0, "R1");
    step(8'b1111_1111, 12, 1, "R1");
    step(8'b0000_0110, 1, 1, "R1");
    step(8'b1001_0011, 3, 2, "R2");
    step(8'b1000_0000, 2, 3, "R2");
    step(8'b0000_0001, 9, 2, "R2");
    step(8'b1000_0001, 15, 3, "R2");
    step(8'b1001_0011, 2, 4, "R3");
    step(8'b1001_0011, 10, 5, "R3");
    step(8'b1110_0001, 16, 4, "R3");
    step(8'b0011_0000, -2, 0, "R4");
    step(8'b0000_0011, -2, 1, "R4");
    step(8'b1000_0001, -3, 3, "R4");
    step(8'b1001_0110, -16, 4, "R4");
    step(8'b1010_1010, -5, 5, "R4");
    step(8'b1000_0000, 1, 0, "R5");
    step(8'b0100_0000, 1, 0, "R5");
    step(8'b0000_0001, 1, 1, "R6");
    step(8'b0000_0010, 1, 1, "R6");
    step(8'b1101_0110, 7, 6, "R7");
    step(8'b0101_1001, -9, 7, "R7");
    step(8'b1111_1111, 3, 4, "R8");
    for (int c = 0; c < 8; c++) step(8'hA5, 0, c, "R8");

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", "out_valid low", int'(out_valid), 0);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "sync reset", int'({out_valid, left_lost, right_lost, data_out}), 0);
    rst = 1'b0;

    for (int n = 0; n < 600; n++) begin
      int code = int'($urandom_range(0, 7));
      int amt = int'($urandom_range(0, 31)) - 16;
      step(W'($urandom), amt, code, tag_of(code));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule